// File: doc/BRIEF.md
# Double-Data-Rate Input Capture to Single-Rate Word Pairs

This block takes an input bus that carries a new word on every edge of its source clock and presents those words to the fabric as a pair of words. The pair moves together on the rising edge of one capture clock. The capture clock is supplied already delayed by a quarter period from the source clock, so each of its edges lands in the middle of a data eye. The word sent in the first half of a source period is sampled on the capture clock's rising edge. The word sent in the second half is sampled on the capture clock's falling edge and then moved across to the rising edge. Downstream logic therefore sees both words in the same cycle.

A build-time parameter selects how the two words are paired. In the default pairing the rising-edge output is the word sampled at the current edge, and the falling-edge output is the word from the half cycle before it. In same-period pairing the rising-edge word is held back by one more cycle, so both outputs belong to one source period. A valid flag shows when the pipeline has filled after reset.

Top module: `ddr_in_capture`

## Requirements
- R1: While `rst` is high at a rising edge of `clk_cap`, the next values of `dout_rise`, `dout_fall` and `dout_valid` are all zero.
- R2: With `PAIR_MODE` = 0, after each rising edge that has `rst` low, `dout_rise` equals the `din` value sampled at that edge.
- R3: In both modes, after each rising edge that has `rst` low, `dout_fall` equals the `din` value sampled at the falling edge just before it. This assumes `rst` was low at that falling edge.
- R4: `dout_rise`, `dout_fall` and `dout_valid` change only on rising edges of `clk_cap`. A falling edge leaves all three unchanged.
- R5: With `PAIR_MODE` = 1, after each rising edge, `dout_rise` equals the `din` value sampled at the rising edge before. It is therefore the first-half word of the same source period as the `dout_fall` word.
- R6: With `PAIR_MODE` = 0, `dout_valid` is high after the first rising edge that has `rst` low, and it stays high until reset.
- R7: With `PAIR_MODE` = 1, `dout_valid` stays low after the first rising edge that has `rst` low. It becomes high after the second such edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_cap | input | 1 | Capture clock, a quarter period behind the source clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DATA_W | Double-rate data bus, one word per source clock edge |
| dout_rise | output | DATA_W | Word sampled on the capture rising edge |
| dout_fall | output | DATA_W | Word sampled on the capture falling edge, re-timed to the rising edge |
| dout_valid | output | 1 | High once the selected pipeline depth has filled after reset |

## Verification
A falling-edge register that has lost its data, or that is clocked on the wrong edge, shows up at the first rising edge after the bad sample. `dout_fall` then carries the wrong half-cycle's word, or it carries a word equal to `dout_rise`. A missing or extra delay stage on the rising path shifts `dout_rise` by one word against the stimulus table. This shows within one cycle of the first distinct word, and a valid flag of the wrong depth shows on the first edge after reset is released. Because every vector uses two distinct values per period, any swap of the two words, or any sampling on the wrong edge, shows up immediately.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;
  // Number of rising edges needed before both outputs carry captured data.
  function automatic int fill_depth(input int pair_mode);
    return (pair_mode == 1) ? 2 : 1;
  endfunction
endpackage

// File: rtl/ddr_cap_rise.sv
module ddr_cap_rise #(
  parameter int DATA_W = 8,
  parameter int EXTRA  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] stage0;

  always_ff @(posedge clk) begin
    if (rst) stage0 <= '0;
    else     stage0 <= d;
  end

  generate
    if (EXTRA != 0) begin : g_delay
      logic [DATA_W-1:0] stage1;
      always_ff @(posedge clk) begin
        if (rst) stage1 <= '0;
        else     stage1 <= stage0;
      end
      assign q = stage1;
    end else begin : g_direct
      assign q = stage0;
    end
  endgenerate
endmodule

// File: rtl/ddr_cap_fall.sv
module ddr_cap_fall #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] neg_word;

  // Sampled on the inverted capture clock, in the middle of the second-half eye.
  always_ff @(negedge clk) begin
    if (rst) neg_word <= '0;
    else     neg_word <= d;
  end

  // Re-timed into the rising-edge domain.
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= neg_word;
  end
endmodule

// File: rtl/ddr_cap_fill.sv
module ddr_cap_fill #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst,
  output logic full
);
  logic [DEPTH-1:0] fill_sr;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) fill_sr <= '0;
        else     fill_sr <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) fill_sr <= '0;
        else     fill_sr <= {fill_sr[DEPTH-2:0], 1'b1};
      end
    end
  endgenerate

  assign full = fill_sr[DEPTH-1];
endmodule

// File: rtl/ddr_in_capture.sv
module ddr_in_capture #(
  parameter int DATA_W    = 8,
  parameter int PAIR_MODE = 0
) (
  input  logic              clk_cap,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout_rise,
  output logic [DATA_W-1:0] dout_fall,
  output logic              dout_valid
);
  localparam int FILL = ddr_cap_pkg::fill_depth(PAIR_MODE);
  localparam int EXTRA_A = (PAIR_MODE == 1) ? 1 : 0;

  ddr_cap_rise #(.DATA_W(DATA_W), .EXTRA(EXTRA_A)) u_rise (
    .clk (clk_cap),
    .rst (rst),
    .d   (din),
    .q   (dout_rise)
  );

  ddr_cap_fall #(.DATA_W(DATA_W)) u_fall (
    .clk (clk_cap),
    .rst (rst),
    .d   (din),
    .q   (dout_fall)
  );

  ddr_cap_fill #(.DEPTH(FILL)) u_fill (
    .clk  (clk_cap),
    .rst  (rst),
    .full (dout_valid)
  );
endmodule

// File: rtl/ddr_in_capture_chk.sv
module ddr_in_capture_chk #(
  parameter int DATA_W    = 8,
  parameter int PAIR_MODE = 0
) (
  input logic              clk_cap,
  input logic              rst,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout_rise,
  input logic [DATA_W-1:0] dout_fall,
  input logic              dout_valid
);
  // Observer of the second-half word, as the bus shows it on a falling edge.
  logic [DATA_W-1:0] seen_b;
  always_ff @(negedge clk_cap) begin
    if (rst) seen_b <= '0;
    else     seen_b <= din;
  end

  p_fall_word_r3: assert property (@(posedge clk_cap) disable iff (rst)
    !rst |=> dout_fall == $past(seen_b));

  generate
    if (PAIR_MODE == 1) begin : g_m1
      p_rise_same_period_r5: assert property (@(posedge clk_cap) disable iff (rst)
        dout_valid |=> dout_rise == $past(din, 2));
      p_valid_late_r7: assert property (@(posedge clk_cap) disable iff (rst)
        (!rst && $past(rst)) |=> !dout_valid);
      p_valid_set_r7: assert property (@(posedge clk_cap) disable iff (rst)
        (!rst && !$past(rst)) |=> dout_valid);
    end else begin : g_m0
      p_rise_word_r2: assert property (@(posedge clk_cap) disable iff (rst)
        !rst |=> dout_rise == $past(din));
      p_valid_first_r6: assert property (@(posedge clk_cap) disable iff (rst)
        !rst |=> dout_valid);
    end
  endgenerate
endmodule

bind ddr_in_capture ddr_in_capture_chk #(.DATA_W(DATA_W), .PAIR_MODE(PAIR_MODE)) u_chk (
  .clk_cap    (clk_cap),
  .rst        (rst),
  .din        (din),
  .dout_rise  (dout_rise),
  .dout_fall  (dout_fall),
  .dout_valid (dout_valid)
);

// File: tb/ddr_in_capture_bench.sv
module ddr_in_capture_bench;
  localparam int W = 8;
  localparam int NV = 12;
  // Each entry: {first-half word A, second-half word B} of one source period.
  localparam logic [15:0] VEC [NV] = '{
    16'hA5_5A, 16'h00_FF, 16'hFF_00, 16'h01_80, 16'h12_34, 16'h55_AA,
    16'hC3_3C, 16'h7E_81, 16'h0F_F0, 16'h99_66, 16'hDE_AD, 16'hBE_EF
  };

  logic         clk_cap = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] r0, f0, r1, f1;
  logic         v0, v1;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_cap = ~clk_cap;

  ddr_in_capture #(.DATA_W(W), .PAIR_MODE(0)) u_ddr_in_capture (
    .clk_cap(clk_cap), .rst(rst), .din(din),
    .dout_rise(r0), .dout_fall(f0), .dout_valid(v0));

  ddr_in_capture #(.DATA_W(W), .PAIR_MODE(1)) u_ddr_in_capture_m1 (
    .clk_cap(clk_cap), .rst(rst), .din(din),
    .dout_rise(r1), .dout_fall(f1), .dout_valid(v1));

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 5000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] prev_a, prev_b, hr0, hf0, hr1, hf1;
    logic hv0, hv1;
    // Reset state (R1)
    repeat (3) @(posedge clk_cap);
    #5;
    check("R1 rise m0", r0, '0);
    check("R1 fall m0", f0, '0);
    check("R1 valid m0", {7'd0, v0}, 8'd0);
    check("R1 rise m1", r1, '0);
    check("R1 valid m1", {7'd0, v1}, 8'd0);
    // Release so the next falling edge already has rst low.
    din = 8'h3C;
    rst = 1'b0;
    prev_a = '0;
    prev_b = 8'h3C;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_cap);
      #2;
      if (i > 0) begin
        check("R4 rise m0 stable", r0, hr0);
        check("R4 fall m0 stable", f0, hf0);
        check("R4 valid m0 stable", {7'd0, v0}, {7'd0, hv0});
        check("R4 rise m1 stable", r1, hr1);
        check("R4 fall m1 stable", f1, hf1);
        check("R4 valid m1 stable", {7'd0, v1}, {7'd0, hv1});
      end
      #3 din = VEC[i][15:8];
      @(posedge clk_cap);
      #5;
      check("R2 rise m0", r0, VEC[i][15:8]);
      check("R3 fall m0", f0, prev_b);
      check("R6 valid m0", {7'd0, v0}, 8'd1);
      check("R5 rise m1", r1, prev_a);
      check("R3 fall m1", f1, prev_b);
      check("R7 valid m1", {7'd0, v1}, (i == 0) ? 8'd0 : 8'd1);
      hr0 = r0; hf0 = f0; hv0 = v0; hr1 = r1; hf1 = f1; hv1 = v1;
      din = VEC[i][7:0];
      prev_a = VEC[i][15:8];
      prev_b = VEC[i][7:0];
    end

    // Reset in mid-stream (R1), then refill (R6, R7)
    @(posedge clk_cap);
    #2 rst = 1'b1;
    @(posedge clk_cap);
    #3;
    check("R1 mid rise m0", r0, '0);
    check("R1 mid fall m0", f0, '0);
    check("R1 mid valid m0", {7'd0, v0}, 8'd0);
    check("R1 mid rise m1", r1, '0);
    check("R1 mid fall m1", f1, '0);
    check("R1 mid valid m1", {7'd0, v1}, 8'd0);
    @(posedge clk_cap);
    #2 rst = 1'b0;
    din = 8'h96;
    @(negedge clk_cap);
    #5 din = 8'h69;
    @(posedge clk_cap);
    #5;
    check("R6 refill valid m0", {7'd0, v0}, 8'd1);
    check("R2 refill rise m0", r0, 8'h69);
    check("R3 refill fall m0", f0, 8'h96);
    check("R7 refill valid m1", {7'd0, v1}, 8'd0);
    check("R5 refill rise m1", r1, 8'h00);
    check("R3 refill fall m1", f1, 8'h96);
    @(posedge clk_cap);
    #5;
    check("R7 second edge valid m1", {7'd0, v1}, 8'd1);
    check("R5 second edge rise m1", r1, 8'h69);
    check("R3 second edge fall m1", f1, 8'h69);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule